// File: doc/BRIEF.md
# Dual-Word Bidirectional Latch/Register Transceiver

This block sits between two parallel buses, A and B, and moves data in both directions. The data path is split into independent words (two 8-bit words by default). Each word carries an A-to-B path and a B-to-A path. Every path holds one storage cell per bit and runs in one of three ways:

- **Flow-through:** while its latch enable is high, the output follows the input.
- **Latched:** after its latch enable falls, the stored value is held.
- **Edge-registered:** while its latch enable stays low, the path loads a new value on each rising edge of a shared transfer strobe.

A single transfer strobe and a single isolate input serve both words and both directions. Each path also has an active-low output enable. The block does not drive any pins. It produces data outputs and per-bit drive-enable outputs for both ports, and a pad ring or a tri-state wrapper consumes them.

The transfer strobe `xferClk` is a level input sampled on the system clock `clk`. A rising strobe edge is the first `clk` edge at which `xferClk` is sampled high after it was sampled low. Bit `8*w+i` of every bus belongs to word `w` (word 0 in bits 7:0).

Top module: `dual_word_xcvr`

## Requirements
- R1: Each word's latch enables and output enables affect only that word's bits. Word `w` occupies bits `[8w+7:8w]` of every data and enable bus.
- R2: While a path's latch enable is high, its output equals its input in the same cycle. A rising transfer strobe edge does not change that output.
- R3: When a path's latch enable goes low, the path holds the input value present at the last `clk` edge at which the enable was high. The level of `xferClk` does not matter.
- R4: While a path's latch enable is low, the path loads its input at the `clk` edge where a rising transfer strobe edge is detected. The new value appears after that edge.
- R5: While a path's latch enable is low and no rising strobe edge occurs, its output keeps the stored value, whatever its input does.
- R6: For each word, a low A-to-B output enable sets all of that word's `bOutEn` bits to 1; a high one clears them. The same holds for the B-to-A output enable and `aOutEn`.
- R7: When `isolate` is 1, every bit of `aOutEn` and `bOutEn` is 0, whatever the per-word enables are.
- R8: With `isolate` at 0, both ports of a word are enabled when both of its output enables are low. Neither port is enabled when both are high.
- R9: The B-to-A path (`bIn` to `aOut`) follows R2 to R5, using `baLe` and the same transfer strobe.
- R10: A synchronous reset clears all stored values to zero. If `xferClk` is already high when reset ends, that does not count as a rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| xferClk | input | 1 | Shared transfer strobe, sampled on clk |
| isolate | input | 1 | Global disable of all drive enables, active high |
| abLe | input | NUM_WORDS | A-to-B latch enable per word |
| baLe | input | NUM_WORDS | B-to-A latch enable per word |
| abOeN | input | NUM_WORDS | A-to-B output enable per word, active low |
| baOeN | input | NUM_WORDS | B-to-A output enable per word, active low |
| aIn | input | NUM_WORDS*WORD_BITS | Data seen on port A |
| bIn | input | NUM_WORDS*WORD_BITS | Data seen on port B |
| aOut | output | NUM_WORDS*WORD_BITS | Data to drive onto port A |
| aOutEn | output | NUM_WORDS*WORD_BITS | Per-bit drive enable for port A |
| bOut | output | NUM_WORDS*WORD_BITS | Data to drive onto port B |
| bOutEn | output | NUM_WORDS*WORD_BITS | Per-bit drive enable for port B |

## Verification
The hardest case to reach from the ports is a path that holds a value which its input no longer shows. That value must survive while the strobe moves, then be replaced at exactly one `clk` edge.

The stimulus reaches this case in three steps. First, it changes the input on the same cycle the latch enable drops. Next, it keeps the strobe high so that repeated clocks carry no rising edge. Finally, it sends one low-high strobe pulse and samples the output both before and after the capturing edge.

A mixed setting, with one word flowing through and the other held, exposes any crosstalk between words. The same pulse then captures the held word while the other word is still transparent.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  // Strobes from control to one storage path of one word
  typedef struct packed {
    logic follow;   // latch enable high: transparent, storage tracks input
    logic capture;  // latch enable low and strobe rose: load input
  } pathCtl_t;

  typedef enum logic {
    DIR_AB = 1'b0,
    DIR_BA = 1'b1
  } xferDir_e;
endpackage

// File: rtl/xcvr_ctrl.sv
module xcvr_ctrl
  import xcvr_pkg::*;
#(
  parameter int NUM_WORDS = 2,
  parameter int WORD_BITS = 8,
  localparam int BUS_BITS = NUM_WORDS * WORD_BITS
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            xferClk,
  input  logic                            isolate,
  input  logic [NUM_WORDS-1:0]            abLe,
  input  logic [NUM_WORDS-1:0]            baLe,
  input  logic [NUM_WORDS-1:0]            abOeN,
  input  logic [NUM_WORDS-1:0]            baOeN,
  output pathCtl_t [NUM_WORDS-1:0]        abCtl,
  output pathCtl_t [NUM_WORDS-1:0]        baCtl,
  output logic [BUS_BITS-1:0]             aOutEn,
  output logic [BUS_BITS-1:0]             bOutEn
);
  logic xferClkQ;
  logic xferRise;

  // Reset to 1 so a strobe already high at reset release is not an edge
  always_ff @(posedge clk) begin
    if (rst) xferClkQ <= 1'b1;
    else     xferClkQ <= xferClk;
  end

  assign xferRise = xferClk & ~xferClkQ;

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    logic bDrive;
    logic aDrive;

    always_comb begin
      abCtl[w].follow  = abLe[w];
      abCtl[w].capture = ~abLe[w] & xferRise;
      baCtl[w].follow  = baLe[w];
      baCtl[w].capture = ~baLe[w] & xferRise;
    end

    assign bDrive = ~isolate & ~abOeN[w];
    assign aDrive = ~isolate & ~baOeN[w];
    assign bOutEn[w*WORD_BITS +: WORD_BITS] = {WORD_BITS{bDrive}};
    assign aOutEn[w*WORD_BITS +: WORD_BITS] = {WORD_BITS{aDrive}};
  end

  // R7
  isolate_chk: assert property (@(posedge clk) disable iff (rst)
    isolate |-> (aOutEn == '0 && bOutEn == '0));

  // R4
  capture_edge_chk: assert property (@(posedge clk) disable iff (rst)
    abCtl[0].capture |-> (xferClk && !$past(xferClk)));

  // R2
  follow_no_capture_chk: assert property (@(posedge clk) disable iff (rst)
    abLe[0] |-> !abCtl[0].capture);
endmodule

// File: rtl/xcvr_cell.sv
module xcvr_cell
  import xcvr_pkg::*;
#(
  parameter int WORD_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  pathCtl_t             ctl,
  input  logic [WORD_BITS-1:0] din,
  output logic [WORD_BITS-1:0] dout
);
  logic [WORD_BITS-1:0] store;

  // Tracking while transparent makes the falling-enable capture exact
  always_ff @(posedge clk) begin
    if (rst)                           store <= '0;
    else if (ctl.follow | ctl.capture) store <= din;
  end

  assign dout = ctl.follow ? din : store;

  // R5
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!ctl.follow && !ctl.capture) |=> $stable(store));

  // R4
  load_chk: assert property (@(posedge clk) disable iff (rst)
    ctl.capture |=> (store == $past(din)));

  // R3
  track_chk: assert property (@(posedge clk) disable iff (rst)
    ctl.follow |=> (store == $past(din)));

  // R10
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (store == '0));
endmodule

// File: rtl/xcvr_datapath.sv
module xcvr_datapath
  import xcvr_pkg::*;
#(
  parameter int NUM_WORDS = 2,
  parameter int WORD_BITS = 8,
  localparam int BUS_BITS = NUM_WORDS * WORD_BITS
) (
  input  logic                     clk,
  input  logic                     rst,
  input  pathCtl_t [NUM_WORDS-1:0] abCtl,
  input  pathCtl_t [NUM_WORDS-1:0] baCtl,
  input  logic [BUS_BITS-1:0]      aIn,
  input  logic [BUS_BITS-1:0]      bIn,
  output logic [BUS_BITS-1:0]      aOut,
  output logic [BUS_BITS-1:0]      bOut
);
  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    for (genvar d = 0; d < 2; d++) begin : g_dir
      localparam xferDir_e DIR = xferDir_e'(d);
      if (DIR == DIR_AB) begin : g_ab
        xcvr_cell #(.WORD_BITS(WORD_BITS)) u_cell (
          .clk  (clk),
          .rst  (rst),
          .ctl  (abCtl[w]),
          .din  (aIn[w*WORD_BITS +: WORD_BITS]),
          .dout (bOut[w*WORD_BITS +: WORD_BITS])
        );
      end else begin : g_ba
        xcvr_cell #(.WORD_BITS(WORD_BITS)) u_cell (
          .clk  (clk),
          .rst  (rst),
          .ctl  (baCtl[w]),
          .din  (bIn[w*WORD_BITS +: WORD_BITS]),
          .dout (aOut[w*WORD_BITS +: WORD_BITS])
        );
      end
    end
  end
endmodule

// File: rtl/dual_word_xcvr.sv
module dual_word_xcvr
  import xcvr_pkg::*;
#(
  parameter int NUM_WORDS = 2,
  parameter int WORD_BITS = 8,
  localparam int BUS_BITS = NUM_WORDS * WORD_BITS
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 xferClk,
  input  logic                 isolate,
  input  logic [NUM_WORDS-1:0] abLe,
  input  logic [NUM_WORDS-1:0] baLe,
  input  logic [NUM_WORDS-1:0] abOeN,
  input  logic [NUM_WORDS-1:0] baOeN,
  input  logic [BUS_BITS-1:0]  aIn,
  input  logic [BUS_BITS-1:0]  bIn,
  output logic [BUS_BITS-1:0]  aOut,
  output logic [BUS_BITS-1:0]  aOutEn,
  output logic [BUS_BITS-1:0]  bOut,
  output logic [BUS_BITS-1:0]  bOutEn
);
  pathCtl_t [NUM_WORDS-1:0] abCtl;
  pathCtl_t [NUM_WORDS-1:0] baCtl;

  xcvr_ctrl #(.NUM_WORDS(NUM_WORDS), .WORD_BITS(WORD_BITS)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .xferClk (xferClk),
    .isolate (isolate),
    .abLe    (abLe),
    .baLe    (baLe),
    .abOeN   (abOeN),
    .baOeN   (baOeN),
    .abCtl   (abCtl),
    .baCtl   (baCtl),
    .aOutEn  (aOutEn),
    .bOutEn  (bOutEn)
  );

  xcvr_datapath #(.NUM_WORDS(NUM_WORDS), .WORD_BITS(WORD_BITS)) u_data (
    .clk   (clk),
    .rst   (rst),
    .abCtl (abCtl),
    .baCtl (baCtl),
    .aIn   (aIn),
    .bIn   (bIn),
    .aOut  (aOut),
    .bOut  (bOut)
  );

  // R2
  flow_ab_chk: assert property (@(posedge clk) disable iff (rst)
    abLe[0] |-> (bOut[WORD_BITS-1:0] == aIn[WORD_BITS-1:0]));

  // R9
  flow_ba_chk: assert property (@(posedge clk) disable iff (rst)
    baLe[0] |-> (aOut[WORD_BITS-1:0] == bIn[WORD_BITS-1:0]));

  // R8
  both_on_chk: assert property (@(posedge clk) disable iff (rst)
    (!isolate && abOeN[0] == 1'b0 && baOeN[0] == 1'b0)
      |-> (aOutEn[0] && bOutEn[0]));
endmodule

// File: tb/dual_word_xcvr_tb.sv
module dual_word_xcvr_tb;
  localparam int NW = 2;
  localparam int WB = 8;
  localparam int BB = NW * WB;

  typedef struct {
    string          tag;
    logic [BB-1:0]  ea;
    logic [BB-1:0]  eb;
    logic [BB-1:0]  eaEn;
    logic [BB-1:0]  ebEn;
  } expItem_t;

  logic clk = 1'b0;
  logic rst, xferClk, isolate;
  logic [NW-1:0] abLe, baLe, abOeN, baOeN;
  logic [BB-1:0] aIn, bIn, aOut, aOutEn, bOut, bOutEn;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  expItem_t scoreQ[$];
  event sampleEv;

  always #2.5 clk = ~clk;

  dual_word_xcvr #(.NUM_WORDS(NW), .WORD_BITS(WB)) u_dut (
    .clk(clk), .rst(rst), .xferClk(xferClk), .isolate(isolate),
    .abLe(abLe), .baLe(baLe), .abOeN(abOeN), .baOeN(baOeN),
    .aIn(aIn), .bIn(bIn), .aOut(aOut), .aOutEn(aOutEn),
    .bOut(bOut), .bOutEn(bOutEn)
  );

  // Driver side: push expectation, wake monitor
  task automatic expectNow(string tag, logic [BB-1:0] ea, logic [BB-1:0] eb,
                           logic [BB-1:0] eaEn, logic [BB-1:0] ebEn);
    expItem_t it;
    #1;
    it.tag = tag; it.ea = ea; it.eb = eb; it.eaEn = eaEn; it.ebEn = ebEn;
    scoreQ.push_back(it);
    -> sampleEv;
    #0;
  endtask

  // Monitor: pop and compare against the ports
  initial begin
    forever begin
      @(sampleEv);
      while (scoreQ.size() > 0) begin
        expItem_t it;
        it = scoreQ.pop_front();
        checks++;
        if (aOut !== it.ea || bOut !== it.eb ||
            aOutEn !== it.eaEn || bOutEn !== it.ebEn) begin
          fails++;
          $display("FAIL %s: aOut=%h bOut=%h aEn=%h bEn=%h exp aOut=%h bOut=%h aEn=%h bEn=%h",
                   it.tag, aOut, bOut, aOutEn, bOutEn, it.ea, it.eb, it.eaEn, it.ebEn);
        end
      end
    end
  end

  task automatic nx();
    @(negedge clk);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run hung, actual=timeout expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; xferClk = 1'b1; isolate = 1'b0;
    abLe = '0; baLe = '0; abOeN = '1; baOeN = '1;
    aIn = 16'h1234; bIn = '0;
    repeat (3) nx();
    rst = 1'b0;
    // R10: cleared, strobe high at release is no edge
    nx(); expectNow("R10 reset state", 16'h0, 16'h0, 16'h0, 16'h0);
    nx(); expectNow("R10 no edge at release", 16'h0, 16'h0, 16'h0, 16'h0);

    nx(); abOeN = '0; baOeN = '0;
    expectNow("R8 both ports enabled", 16'h0, 16'h0, 16'hFFFF, 16'hFFFF);

    // R2 flow-through
    nx(); abLe = 2'b11; aIn = 16'hA5C3;
    expectNow("R2 transparent", 16'h0, 16'hA5C3, 16'hFFFF, 16'hFFFF);
    nx(); xferClk = 1'b0;
    nx(); xferClk = 1'b1;
    expectNow("R2 strobe rise while open", 16'h0, 16'hA5C3, 16'hFFFF, 16'hFFFF);
    nx(); expectNow("R2 after strobe edge", 16'h0, 16'hA5C3, 16'hFFFF, 16'hFFFF);
    nx(); aIn = 16'h1F2E;
    expectNow("R2 follows new input", 16'h0, 16'h1F2E, 16'hFFFF, 16'hFFFF);

    // R3 latch on enable fall, strobe high
    nx(); aIn = 16'h7788;
    nx(); abLe = 2'b00; aIn = 16'h0000;
    expectNow("R3 latched on fall", 16'h0, 16'h7788, 16'hFFFF, 16'hFFFF);
    nx(); aIn = 16'h9999;
    nx(); expectNow("R5 hold without edge", 16'h0, 16'h7788, 16'hFFFF, 16'hFFFF);

    // R4 edge-registered
    nx(); aIn = 16'hC0DE; xferClk = 1'b0;
    nx(); xferClk = 1'b1;
    expectNow("R5 before capturing edge", 16'h0, 16'h7788, 16'hFFFF, 16'hFFFF);
    nx(); expectNow("R4 captured on strobe rise", 16'h0, 16'hC0DE, 16'hFFFF, 16'hFFFF);
    nx(); aIn = 16'h1111;
    nx(); expectNow("R4 no second capture", 16'h0, 16'hC0DE, 16'hFFFF, 16'hFFFF);

    // R1 word independence
    nx(); abLe = 2'b10; aIn = 16'h2222;
    expectNow("R1 word1 open word0 held", 16'h0, 16'h22DE, 16'hFFFF, 16'hFFFF);
    nx(); abOeN = 2'b10;
    expectNow("R6 word1 B disabled", 16'h0, 16'h22DE, 16'hFFFF, 16'h00FF);

    nx(); isolate = 1'b1;
    expectNow("R7 isolate overrides", 16'h0, 16'h22DE, 16'h0, 16'h0);
    nx(); isolate = 1'b0; abOeN = 2'b11; baOeN = 2'b11;
    expectNow("R8 both disabled", 16'h0, 16'h22DE, 16'h0, 16'h0);

    // R9 B-to-A
    nx(); baLe = 2'b11; bIn = 16'h4321;
    expectNow("R9 BA transparent", 16'h4321, 16'h22DE, 16'h0, 16'h0);
    nx(); bIn = 16'h5A5A;
    nx(); baLe = 2'b00; bIn = 16'h0000;
    expectNow("R9 BA latched on fall", 16'h5A5A, 16'h22DE, 16'h0, 16'h0);
    nx(); bIn = 16'h6B6B; xferClk = 1'b0;
    nx(); xferClk = 1'b1;
    nx(); expectNow("R9 R1 BA capture, AB word0 captured", 16'h6B6B, 16'h2222, 16'h0, 16'h0);

    // R10 reset clears stored values
    nx(); abLe = '0; baLe = '0; rst = 1'b1;
    nx(); rst = 1'b0;
    nx(); expectNow("R10 cleared after reset", 16'h0, 16'h0, 16'h0, 16'h0);

    nx();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule